// File: doc/BRIEF.md
# Floating-Point Operand Prenormalization Stage

This block sits between operand fetch and the arithmetic datapath of a floating-point unit. Each instruction brings three source operands (A, B and C), each tagged as single or double precision. The stage sorts each operand into a class (zero, normal, denormal, infinity, quiet NaN, signaling NaN). It widens single-precision values to double precision in hardware. It then recasts all three into one internal format whose exponent is two bits wider than the double-precision exponent field. One spare bit absorbs the shift that normalizing a denormal needs. The other leaves headroom for the exponent adjustments that trapped underflow or overflow require later.

A mode input selects how denormals are handled. With the mode clear, each denormal operand is normalized on its own: its fraction is shifted left until the hidden bit is one, and its exponent drops by the shift. With the mode set, each denormal is replaced by a zero of the same sign. If any operand is a NaN, the stage raises a bypass flag and delivers the final quiet NaN result, chosen by fixed precedence among A, B and C. It also flags an invalid operation when the chosen NaN was signaling. The stage is one register deep, with a valid input and a valid output.

Top module: `fpPrenormStage`

## Requirements
- R1: When `validIn` is high at a rising clock edge, `validOut` is high after that edge and the outputs hold the results for the operands presented at that edge (one cycle of latency). When `validIn` is low at an edge, `validOut` is low after it.
- R2: Each internal operand output is 67 bits: bit 66 is the sign, bits 65:53 are the unbiased exponent as a 13-bit two's complement number, and bits 52:0 are the significand with the hidden bit at position 52. A single-precision operand occupies bits 31:0 of its input. Its 23-bit fraction is placed at significand bits 51:29, with the lower bits zero.
- R3: A normal operand yields exponent = biased exponent − bias (1023 for double, 127 for single) and significand bit 52 = 1 followed by the fraction.
- R4: With `nonIeee` = 0, a denormal operand is normalized: significand bit 52 becomes 1, and the exponent is −1022 (double) or −126 (single) minus the left shift applied. A double with fraction 1 gives −1074, and a single with fraction 1 gives −149.
- R5: With `nonIeee` = 1, a denormal operand becomes exponent 0 and significand 0, with its sign bit kept.
- R6: A zero operand yields exponent 0 and significand 0 with its sign kept. An operand with an all-ones exponent field (infinity or NaN) yields exponent 1024 and significand bit 52 = 0 followed by the widened fraction.
- R7: NaN precedence is A, then B, then C. If any operand is a NaN (all-ones exponent field, nonzero fraction), `nanBypass` is 1 and `nanResult` is a double-precision NaN: the sign of the selected operand, exponent field 0x7FF, fraction bit 51 forced to 1, and the other fraction bits taken from its widened fraction. Otherwise `nanBypass` is 0 and `nanResult` is 0.
- R8: `invalidOp` is 1 exactly when the selected NaN is signaling (widened fraction bit 51 = 0). A signaling NaN in an operand of lower precedence than the selected NaN does not raise it.
- R9: While `validIn` stays low, every data output and flag keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Operands valid this cycle |
| opA | input | 64 | Operand A raw bits (single in bits 31:0) |
| opB | input | 64 | Operand B raw bits |
| opC | input | 64 | Operand C raw bits |
| singleA | input | 1 | Operand A is single precision |
| singleB | input | 1 | Operand B is single precision |
| singleC | input | 1 | Operand C is single precision |
| nonIeee | input | 1 | 1: flush denormals to zero; 0: normalize them |
| validOut | output | 1 | Results valid |
| outA | output | 67 | Internal-format operand A |
| outB | output | 67 | Internal-format operand B |
| outC | output | 67 | Internal-format operand C |
| nanBypass | output | 1 | A NaN operand decides the result |
| nanResult | output | 64 | Quiet double-precision NaN result |
| invalidOp | output | 1 | Selected NaN was signaling |

## Verification
A wrong leading-zero count or exponent adjustment shows up on the output one cycle after the faulty operand enters. It appears as an exponent off by the shift error, or as a significand whose bit 52 is clear, so every denormal pattern sent is checked against an exponent derived from its value. A broken precedence or quieting path appears in the same cycle on `nanResult` and `invalidOp`. The test operands therefore place NaNs of both kinds in several operand positions at once. A capture strobe stuck high would show up as outputs changing during idle cycles.

// File: rtl/fpPrenormPkg.sv
package fpPrenormPkg;
  localparam int OP_W       = 64;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_PAD_W  = DBL_FRAC_W - SGL_FRAC_W;
  localparam int INT_EXP_W  = DBL_EXP_W + 2;
  localparam int SIG_W      = DBL_FRAC_W + 1;
  localparam int INT_W      = 1 + INT_EXP_W + SIG_W;
  localparam int NUM_OPS    = 3;
  localparam int SHIFT_W    = $clog2(SIG_W) + 1;

  typedef struct packed {
    logic                 sign;
    logic [INT_EXP_W-1:0] exp;
    logic [SIG_W-1:0]     sig;
  } intOperand_t;

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_NORMAL, CLS_DENORM, CLS_INF, CLS_QNAN, CLS_SNAN
  } opClass_t;

  typedef struct packed {
    logic capture;
  } ctrlStrobes_t;

  function automatic logic [SHIFT_W-1:0] leadZeros(input logic [DBL_FRAC_W-1:0] v);
    logic [SHIFT_W-1:0] cnt;
    logic found;
    cnt = '0;
    found = 1'b0;
    for (int i = DBL_FRAC_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (v[i]) found = 1'b1;
        else cnt = cnt + 1'b1;
      end
    end
    return cnt;
  endfunction
endpackage

// File: rtl/fpOperandUnpack.sv
module fpOperandUnpack
  import fpPrenormPkg::*;
(
  input  logic [OP_W-1:0]       rawOp,
  input  logic                  isSingle,
  input  logic                  flushDenorm,
  output intOperand_t           unpacked,
  output opClass_t              opClass,
  output logic [DBL_FRAC_W-1:0] fracWide
);
  localparam logic [INT_EXP_W-1:0] DBL_BIAS = INT_EXP_W'(1023);
  localparam logic [INT_EXP_W-1:0] SGL_BIAS = INT_EXP_W'(127);
  localparam logic [INT_EXP_W-1:0] DBL_MIN  = INT_EXP_W'(-1022);
  localparam logic [INT_EXP_W-1:0] SGL_MIN  = INT_EXP_W'(-126);
  localparam logic [INT_EXP_W-1:0] SPECIAL  = INT_EXP_W'(1024);

  logic                 sign;
  logic [DBL_EXP_W-1:0] expField;
  logic                 expAllOnes;
  logic                 expAllZero;
  logic [INT_EXP_W-1:0] bias;
  logic [INT_EXP_W-1:0] minExp;
  logic [SHIFT_W-1:0]   shiftAmt;
  logic [SIG_W-1:0]     normSig;

  always_comb begin
    if (isSingle) begin
      sign       = rawOp[31];
      expField   = {{(DBL_EXP_W-SGL_EXP_W){1'b0}}, rawOp[30:23]};
      expAllOnes = &rawOp[30:23];
      expAllZero = ~|rawOp[30:23];
      fracWide   = {rawOp[SGL_FRAC_W-1:0], {SGL_PAD_W{1'b0}}};
      bias       = SGL_BIAS;
      minExp     = SGL_MIN;
    end else begin
      sign       = rawOp[OP_W-1];
      expField   = rawOp[OP_W-2:DBL_FRAC_W];
      expAllOnes = &rawOp[OP_W-2:DBL_FRAC_W];
      expAllZero = ~|rawOp[OP_W-2:DBL_FRAC_W];
      fracWide   = rawOp[DBL_FRAC_W-1:0];
      bias       = DBL_BIAS;
      minExp     = DBL_MIN;
    end
  end

  always_comb begin
    shiftAmt = leadZeros(fracWide) + 1'b1;
    normSig  = {1'b0, fracWide} << shiftAmt;
  end

  always_comb begin
    unpacked.sign = sign;
    if (expAllOnes) begin
      opClass      = (fracWide == '0) ? CLS_INF :
                     (fracWide[DBL_FRAC_W-1] ? CLS_QNAN : CLS_SNAN);
      unpacked.exp = SPECIAL;
      unpacked.sig = {1'b0, fracWide};
    end else if (expAllZero && fracWide == '0) begin
      opClass      = CLS_ZERO;
      unpacked.exp = '0;
      unpacked.sig = '0;
    end else if (expAllZero) begin
      opClass = CLS_DENORM;
      if (flushDenorm) begin
        unpacked.exp = '0;
        unpacked.sig = '0;
      end else begin
        unpacked.exp = minExp - INT_EXP_W'(shiftAmt);
        unpacked.sig = normSig;
      end
    end else begin
      opClass      = CLS_NORMAL;
      unpacked.exp = {2'b00, expField} - bias;
      unpacked.sig = {1'b1, fracWide};
    end
  end
endmodule

// File: rtl/fpPrenormCtrl.sv
module fpPrenormCtrl
  import fpPrenormPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  output ctrlStrobes_t strobes,
  output logic         validOut
);
  always_comb strobes.capture = validIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end
endmodule

// File: rtl/fpPrenormDatapath.sv
module fpPrenormDatapath
  import fpPrenormPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strobes,
  input  logic [NUM_OPS-1:0][OP_W-1:0] rawOps,
  input  logic [NUM_OPS-1:0]           isSingle,
  input  logic                         nonIeee,
  output intOperand_t [NUM_OPS-1:0]    opsOut,
  output logic                         nanBypass,
  output logic [OP_W-1:0]              nanResult,
  output logic                         invalidOp
);
  intOperand_t [NUM_OPS-1:0] opsNext;
  opClass_t                  opClass [NUM_OPS];
  logic [DBL_FRAC_W-1:0]     fracWide [NUM_OPS];

  logic            bypassNext;
  logic [OP_W-1:0] resultNext;
  logic            invalidNext;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_unpack
    fpOperandUnpack u_unpack (
      .rawOp      (rawOps[i]),
      .isSingle   (isSingle[i]),
      .flushDenorm(nonIeee),
      .unpacked   (opsNext[i]),
      .opClass    (opClass[i]),
      .fracWide   (fracWide[i])
    );
  end

  // Lowest operand index wins: scan from C down to A.
  always_comb begin
    bypassNext  = 1'b0;
    resultNext  = '0;
    invalidNext = 1'b0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (opClass[i] == CLS_QNAN || opClass[i] == CLS_SNAN) begin
        bypassNext  = 1'b1;
        invalidNext = (opClass[i] == CLS_SNAN);
        resultNext  = {opsNext[i].sign, {DBL_EXP_W{1'b1}}, 1'b1,
                       fracWide[i][DBL_FRAC_W-2:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opsOut    <= '0;
      nanBypass <= 1'b0;
      nanResult <= '0;
      invalidOp <= 1'b0;
    end else if (strobes.capture) begin
      opsOut    <= opsNext;
      nanBypass <= bypassNext;
      nanResult <= resultNext;
      invalidOp <= invalidNext;
    end
  end

  assert_quiet_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    nanBypass |-> (&nanResult[OP_W-2:DBL_FRAC_W]) && nanResult[DBL_FRAC_W-1]);

  assert_invalid_with_nan_R8: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp |-> nanBypass);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.capture) |-> ($stable(opsOut) && $stable(nanResult)
                                 && $stable(nanBypass) && $stable(invalidOp)));

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_chk
    assert_hidden_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
      (opsOut[i].exp != '0 && opsOut[i].exp != INT_EXP_W'(1024))
        |-> opsOut[i].sig[SIG_W-1]);

    assert_flush_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.capture && nonIeee)
        |-> ($signed(opsOut[i].exp) >= $signed(INT_EXP_W'(-1022))));
  end
endmodule

// File: rtl/fpPrenormStage.sv
module fpPrenormStage
  import fpPrenormPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            validIn,
  input  logic [63:0]     opA,
  input  logic [63:0]     opB,
  input  logic [63:0]     opC,
  input  logic            singleA,
  input  logic            singleB,
  input  logic            singleC,
  input  logic            nonIeee,
  output logic            validOut,
  output logic [66:0]     outA,
  output logic [66:0]     outB,
  output logic [66:0]     outC,
  output logic            nanBypass,
  output logic [63:0]     nanResult,
  output logic            invalidOp
);
  ctrlStrobes_t              strobes;
  intOperand_t [NUM_OPS-1:0] opsOut;

  fpPrenormCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .strobes (strobes),
    .validOut(validOut)
  );

  fpPrenormDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rawOps   ({opC, opB, opA}),
    .isSingle ({singleC, singleB, singleA}),
    .nonIeee  (nonIeee),
    .opsOut   (opsOut),
    .nanBypass(nanBypass),
    .nanResult(nanResult),
    .invalidOp(invalidOp)
  );

  assign outA = opsOut[0];
  assign outB = opsOut[1];
  assign outC = opsOut[2];
endmodule

// File: tb/tb_fpPrenormStage.sv
module tb_fpPrenormStage;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [63:0] opA = '0, opB = '0, opC = '0;
  logic        singleA = 1'b0, singleB = 1'b0, singleC = 1'b0;
  logic        nonIeee = 1'b0;
  logic        validOut, nanBypass, invalidOp;
  logic [66:0] outA, outB, outC;
  logic [63:0] nanResult;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string       name;
    string       req;
    logic [66:0] a, b, c;
    logic        bypass;
    logic [63:0] result;
    logic        invalid;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastExp;

  fpPrenormStage dut (
    .clk(clk), .rstN(rstN), .validIn(validIn),
    .opA(opA), .opB(opB), .opC(opC),
    .singleA(singleA), .singleB(singleB), .singleC(singleC),
    .nonIeee(nonIeee), .validOut(validOut),
    .outA(outA), .outB(outB), .outC(outC),
    .nanBypass(nanBypass), .nanResult(nanResult), .invalidOp(invalidOp)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model written from R2..R6: shift until the hidden bit appears.
  function automatic logic [66:0] refOperand(input logic [63:0] raw,
                                             input logic sgl, input logic ni);
    logic s; int e; int bias; int emax; int minE; int ex;
    logic [51:0] f; logic [52:0] sig;
    if (sgl) begin
      s = raw[31]; e = int'(raw[30:23]); f = {raw[22:0], 29'b0};
      bias = 127; emax = 255; minE = -126;
    end else begin
      s = raw[63]; e = int'(raw[62:52]); f = raw[51:0];
      bias = 1023; emax = 2047; minE = -1022;
    end
    if (e == 0 && f == '0) return {s, 13'd0, 53'd0};
    if (e == emax) return {s, 13'd1024, 1'b0, f};
    if (e == 0) begin
      if (ni) return {s, 13'd0, 53'd0};
      sig = {1'b0, f};
      ex = minE;
      while (!sig[52]) begin
        sig = sig << 1;
        ex--;
      end
      return {s, 13'(ex), sig};
    end
    return {s, 13'(e - bias), 1'b1, f};
  endfunction

  function automatic logic isNan(input logic [63:0] raw, input logic sgl);
    if (sgl) return (&raw[30:23]) && (raw[22:0] != '0);
    return (&raw[62:52]) && (raw[51:0] != '0);
  endfunction

  function automatic logic [63:0] quietOf(input logic [63:0] raw, input logic sgl);
    logic [51:0] f;
    f = sgl ? {raw[22:0], 29'b0} : raw[51:0];
    return {(sgl ? raw[31] : raw[63]), 11'h7FF, 1'b1, f[50:0]};
  endfunction

  function automatic logic sigBitTop(input logic [63:0] raw, input logic sgl);
    return sgl ? raw[22] : raw[51];
  endfunction

  task automatic send(input string name, input string req,
                      input logic [63:0] a, input logic sa,
                      input logic [63:0] b, input logic sb,
                      input logic [63:0] c, input logic sc, input logic ni);
    expItem_t it;
    @(negedge clk);
    opA = a; opB = b; opC = c;
    singleA = sa; singleB = sb; singleC = sc;
    nonIeee = ni; validIn = 1'b1;
    it.name = name; it.req = req;
    it.a = refOperand(a, sa, ni);
    it.b = refOperand(b, sb, ni);
    it.c = refOperand(c, sc, ni);
    it.bypass = 1'b0; it.result = '0; it.invalid = 1'b0;
    if (isNan(a, sa)) begin
      it.bypass = 1'b1; it.result = quietOf(a, sa); it.invalid = !sigBitTop(a, sa);
    end else if (isNan(b, sb)) begin
      it.bypass = 1'b1; it.result = quietOf(b, sb); it.invalid = !sigBitTop(b, sb);
    end else if (isNan(c, sc)) begin
      it.bypass = 1'b1; it.result = quietOf(c, sc); it.invalid = !sigBitTop(c, sc);
    end
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    validIn = 1'b0;
    opA = 64'hDEAD_BEEF_0000_0001; opB = 64'h7FF0_0000_0000_0001; opC = '0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: one result per valid cycle, compared against the queue head.
  always @(negedge clk) begin
    if (rstN && !done && validOut) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected validOut: actual 1 expected 0");
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check({it.req, " R2"}, {it.name, " outA"}, outA, it.a);
        check({it.req, " R2"}, {it.name, " outB"}, outB, it.b);
        check({it.req, " R2"}, {it.name, " outC"}, outC, it.c);
        check("R7", {it.name, " nanBypass"}, 67'(nanBypass), 67'(it.bypass));
        check("R7", {it.name, " nanResult"}, 67'(nanResult), 67'(it.result));
        check("R8", {it.name, " invalidOp"}, 67'(invalidOp), 67'(it.invalid));
        lastExp = it;
      end
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset validOut", 67'(validOut), 67'd0);
    check("R7", "reset nanBypass", 67'(nanBypass), 67'd0);
    check("R8", "reset invalidOp", 67'(invalidOp), 67'd0);
    check("R2", "reset outA", outA, 67'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: double normals, including the smallest normal
    send("dblNormal", "R3", 64'h3FF0_0000_0000_0000, 0,
         64'hC004_0000_0000_0000, 0, 64'h0010_0000_0000_0000, 0, 0);
    // R2 R3: single normals widened
    send("sglNormal", "R3", 64'h3F80_0000, 1, 64'hC020_0000, 1, 64'h0080_0000, 1, 0);
    // R4: denormals normalized (-1074, -149, -1023)
    send("denormIeee", "R4", 64'h0000_0000_0000_0001, 0, 64'h0000_0001, 1,
         64'h0008_0000_0000_0000, 0, 0);
    // R4: mixed single denormal with many bits set
    send("denormMixed", "R4", 64'h0007_FFFF_FFFF_FFFF, 0, 64'h8040_0000, 1,
         64'h3FF8_0000_0000_0000, 0, 0);
    // R5: flush keeps sign
    send("flushZero", "R5", 64'h8000_0000_0000_0001, 0, 64'h8040_0000, 1,
         64'h0000_0000_0000_0003, 0, 1);
    // R6: zero and infinity
    send("zeroInf", "R6", 64'h8000_0000_0000_0000, 0, 64'h7F80_0000, 1,
         64'hFFF0_0000_0000_0000, 0, 0);
    // R7 R8: A quiet wins over B signaling, no invalid
    send("nanA", "R7 R8", 64'h7FF8_0000_0000_0123, 0, 64'h7FF0_0000_0000_0001, 0,
         64'h3FF0_0000_0000_0000, 0, 0);
    // R7 R8: B single signaling wins over C quiet, invalid
    send("nanB", "R7 R8", 64'h4000_0000_0000_0000, 0, 64'hFFA0_0001, 1,
         64'h7FF8_0000_0000_0000, 0, 0);
    // R7 R8: only C, double signaling
    send("nanC", "R7 R8", 64'h3F80_0000, 1, 64'h0000_0000_0000_0000, 0,
         64'hFFF4_0000_0000_0000, 0, 0);
    // R5 R7: flush mode does not change NaN precedence
    send("nanFlush", "R5 R7", 64'h0000_0000_0000_0005, 0, 64'h0000_0003, 1,
         64'h7FC0_0001, 1, 1);
    // R1 R9: idle cycles, outputs hold, validOut stays low
    idle(4);
    check("R1", "idle validOut", 67'(validOut), 67'd0);
    check("R9", "hold outA", outA, lastExp.a);
    check("R9", "hold outC", outC, lastExp.c);
    check("R9", "hold nanResult", 67'(nanResult), 67'(lastExp.result));
    check("R9", "hold invalidOp", 67'(invalidOp), 67'(lastExp.invalid));
    check("R1", "queue drained", 67'(expQ.size()), 67'd0);
    finishRun();
  end
endmodule